// File: doc/BRIEF.md
# Priority Interrupt Source Resolver

This block selects which pending interrupt line is reported to the processor for one interrupt class, either the normal class or the fast class. Each bank holds 32 lines. For every line the block receives a pending bit, a mask bit, a class-select bit and a 5-bit priority. Only lines that are pending, unmasked and assigned to the class being resolved are considered. Among those lines the one with the numerically smallest priority wins. When several lines share that smallest priority, the line with the largest global number wins.

The surrounding controller places the block next to its register file. It sets `fastClass` to choose the class and pulses `capture` when it wants a fresh decision. The winning global line number (32 × bank + bit) and a valid flag are registered on that pulse. They then hold steady until the next pulse, so software reads a stable code. The number of banks is set by a parameter, from one to three.

Top module: `irq_source_resolver`

## Requirements
- R1: A line takes part only when its pending bit is 1, its mask bit is 0, and its class-select bit equals `fastClass` (class-select 1 means fast, 0 means normal). Any other line never wins.
- R2: Among the lines that take part, the one with the smallest 5-bit priority value wins, and priority 0 is the most urgent.
- R3: When several lines share the smallest priority, the line with the largest global number wins.
- R4: The reported code is 32 × bank index + bit position, where global line k sits at bit k of the flat input vectors. The code is always below 32 × NUM_BANKS.
- R5: When no line takes part, the captured code is 0 and `winValid` is 0.
- R6: `winValid` is 1 after a capture whenever at least one line took part, including when the winner is line 0.
- R7: `winCode` and `winValid` change only on a rising clock edge with `capture` high. Without `capture` they hold, whatever the inputs do.
- R8: While `rstN` is low, the outputs are cleared to code 0 and valid 0 on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| pending | input | NUM_BANKS*32 | Pending bit per global line |
| maskBits | input | NUM_BANKS*32 | Mask bit per line, 1 blocks the line |
| classSel | input | NUM_BANKS*32 | Class per line, 1 fast, 0 normal |
| prio | input | NUM_BANKS*32*5 | Priority per line; line k at bits [5k+4:5k] |
| fastClass | input | 1 | Class being resolved, 1 fast, 0 normal |
| capture | input | 1 | Register a new decision on this edge |
| winCode | output | 7 | Captured winning global line number |
| winValid | output | 1 | Captured flag, 1 when a winner existed |

## Verification
The bench targets the priority tie. A design that resolves ties toward the lowest index reports line 12 instead of 70, and reports line 0 instead of 95 when every line is pending at equal priority. It puts a fast-class line at better priority than a normal one, so a missing class filter shows up as the wrong code. It also masks a pending line and expects a lower line to win, so an inverted mask is visible. It checks that a lone line 0 still gives a valid flag. This separates a real winner at line 0 from an empty set. It also changes the inputs without `capture`, which exposes a design whose result register follows the tree every cycle. Randomised rounds compare against a sequential model across all three banks.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int BANK_LINES = 32;
  localparam int MAX_BANKS  = 3;
  localparam int PRIO_W     = 5;
  localparam int IDX_W      = $clog2(BANK_LINES * MAX_BANKS + 1);

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [IDX_W-1:0]  idx;
  } cand_t;

  typedef struct packed {
    logic loadResult;
    logic clearResult;
  } res_strobe_t;

  // a beats b: a is live and either b is dead, a is more urgent,
  // or both are equally urgent and a has the higher line number
  function automatic cand_t pickWinner(cand_t a, cand_t b);
    logic aWins;
    aWins = a.valid && (!b.valid || (a.prio < b.prio) ||
                        ((a.prio == b.prio) && (a.idx > b.idx)));
    return aWins ? a : b;
  endfunction
endpackage

// File: rtl/irq_res_ctrl.sv
module irq_res_ctrl
  import irq_res_pkg::*;
(
  input  logic        rstN,
  input  logic        capture,
  output res_strobe_t strobes
);
  always_comb begin
    strobes.clearResult = !rstN;
    strobes.loadResult  = rstN && capture;
  end
endmodule

// File: rtl/irq_res_datapath.sv
module irq_res_datapath
  import irq_res_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                                 clk,
  input  res_strobe_t                          strobes,
  input  logic [NUM_BANKS*BANK_LINES-1:0]        pending,
  input  logic [NUM_BANKS*BANK_LINES-1:0]        maskBits,
  input  logic [NUM_BANKS*BANK_LINES-1:0]        classSel,
  input  logic [NUM_BANKS*BANK_LINES*PRIO_W-1:0] prio,
  input  logic                                 fastClass,
  output logic [IDX_W-1:0]                     winCode,
  output logic                                 winValid
);
  localparam int NLINES = NUM_BANKS * BANK_LINES;
  localparam int LEAVES = 1 << $clog2(NLINES);

  // heap-ordered tree: node 1 is the root, leaves at LEAVES..2*LEAVES-1
  cand_t node [1:2*LEAVES-1];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NLINES) begin : g_real
      assign node[LEAVES+k] = '{
        valid: pending[k] && !maskBits[k] && (classSel[k] == fastClass),
        prio:  prio[k*PRIO_W +: PRIO_W],
        idx:   IDX_W'(k)
      };
    end else begin : g_pad
      assign node[LEAVES+k] = '{valid: 1'b0, prio: '1, idx: IDX_W'(k)};
    end
  end

  for (genvar i = 1; i < LEAVES; i++) begin : g_node
    assign node[i] = pickWinner(node[2*i], node[2*i+1]);
  end

  always_ff @(posedge clk) begin
    if (strobes.clearResult) begin
      winCode  <= '0;
      winValid <= 1'b0;
    end else if (strobes.loadResult) begin
      winCode  <= node[1].valid ? node[1].idx : '0;
      winValid <= node[1].valid;
    end
  end
endmodule

// File: rtl/irq_source_resolver.sv
module irq_source_resolver
  import irq_res_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_BANKS*BANK_LINES-1:0]        pending,
  input  logic [NUM_BANKS*BANK_LINES-1:0]        maskBits,
  input  logic [NUM_BANKS*BANK_LINES-1:0]        classSel,
  input  logic [NUM_BANKS*BANK_LINES*PRIO_W-1:0] prio,
  input  logic                                 fastClass,
  input  logic                                 capture,
  output logic [IDX_W-1:0]                     winCode,
  output logic                                 winValid
);
  res_strobe_t strobes;

  irq_res_ctrl u_ctrl (
    .rstN    (rstN),
    .capture (capture),
    .strobes (strobes)
  );

  irq_res_datapath #(.NUM_BANKS(NUM_BANKS)) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .pending   (pending),
    .maskBits  (maskBits),
    .classSel  (classSel),
    .prio      (prio),
    .fastClass (fastClass),
    .winCode   (winCode),
    .winValid  (winValid)
  );
endmodule

// File: rtl/irq_res_checker.sv
module irq_res_checker
  import irq_res_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic [NUM_BANKS*BANK_LINES-1:0]        pending,
  input logic [NUM_BANKS*BANK_LINES-1:0]        maskBits,
  input logic [NUM_BANKS*BANK_LINES-1:0]        classSel,
  input logic [NUM_BANKS*BANK_LINES*PRIO_W-1:0] prio,
  input logic                                 fastClass,
  input logic                                 capture,
  input logic [IDX_W-1:0]                     winCode,
  input logic                                 winValid
);
  localparam int NLINES = NUM_BANKS * BANK_LINES;

  // R1
  winner_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (!winValid ||
      ((($past(pending) & ~$past(maskBits)) >> winCode) & NLINES'(1)) != '0 &&
      ((($past(classSel) >> winCode) & NLINES'(1)) != '0) == $past(fastClass)));

  // R4
  code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (int'(winCode) < NLINES));

  // R5
  empty_code_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |-> (winCode == '0));

  // R6
  valid_tracks_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (winValid == ($past(pending & ~maskBits &
                   ~(classSel ^ {NLINES{fastClass}})) != '0)));

  // R7
  hold_without_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> ($stable(winCode) && $stable(winValid)));
endmodule

bind irq_source_resolver irq_res_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/tb_irq_source_resolver.sv
module tb_irq_source_resolver;
  import irq_res_pkg::*;
  localparam int NB = 3;
  localparam int NL = NB * BANK_LINES;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL-1:0] pending = '0, maskBits = '0, classSel = '0;
  logic [NL*PRIO_W-1:0] prio;
  logic [PRIO_W-1:0] pr [NL];
  logic fastClass = 1'b0, capture = 1'b0;
  logic [IDX_W-1:0] winCode;
  logic winValid;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  always_comb
    for (int k = 0; k < NL; k++) prio[k*PRIO_W +: PRIO_W] = pr[k];

  irq_source_resolver #(.NUM_BANKS(NB)) dut (.*);

  task automatic check(string req, int actC, int actV, int expC, int expV);
    nChecks++;
    if (actC != expC || actV != expV) begin
      nFails++;
      $display("FAIL %s: code=%0d valid=%0d expected code=%0d valid=%0d",
               req, actC, actV, expC, expV);
    end
  endtask

  task automatic model(output int c, output int v);
    int best = 99;
    c = 0; v = 0;
    for (int k = 0; k < NL; k++)
      if (pending[k] && !maskBits[k] && classSel[k] == fastClass &&
          int'(pr[k]) <= best) begin
        best = int'(pr[k]); c = k; v = 1;
      end
  endtask

  task automatic clearAll();
    pending = '0; maskBits = '0; classSel = '0;
    for (int k = 0; k < NL; k++) pr[k] = 5'd16;
  endtask

  task automatic doCapture();
    capture = 1'b1;
    @(posedge clk);
    @(negedge clk);
    capture = 1'b0;
  endtask

  task automatic runExpect(string req, int expC, int expV);
    int mc, mv;
    doCapture();
    model(mc, mv);
    check({req, " model"}, int'(winCode), int'(winValid), mc, mv);
    check(req, int'(winCode), int'(winValid), expC, expV);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 reset", int'(winCode), int'(winValid), 0, 0);
    rstN = 1'b1;
  endtask

  task automatic t_empty();
    clearAll(); pending[4] = 1'b1; maskBits[4] = 1'b1;
    runExpect("R5 empty set", 0, 0);
  endtask

  task automatic t_line0();
    clearAll(); pending[0] = 1'b1;
    runExpect("R6 line0 valid", 0, 1);
  endtask

  task automatic t_mask();
    clearAll(); pending[10] = 1; pending[3] = 1; maskBits[10] = 1;
    pr[10] = 0; pr[3] = 9;
    runExpect("R1 mask", 3, 1);
  endtask

  task automatic t_class();
    clearAll(); pending[20] = 1; classSel[20] = 1; pr[20] = 0;
    pending[5] = 1; pr[5] = 9;
    fastClass = 1'b0; runExpect("R1 normal class", 5, 1);
    fastClass = 1'b1; runExpect("R1 fast class", 20, 1);
    fastClass = 1'b0;
  endtask

  task automatic t_priority();
    clearAll(); pending[7] = 1; pr[7] = 3; pending[40] = 1; pr[40] = 1;
    pending[90] = 1; pr[90] = 2;
    runExpect("R2 lowest value wins", 40, 1);
    pr[7] = 0; runExpect("R2 zero most urgent", 7, 1);
  endtask

  task automatic t_tie();
    clearAll(); pending[12] = 1; pending[70] = 1; pending[33] = 1;
    pr[12] = 4; pr[70] = 4; pr[33] = 4;
    runExpect("R3 tie high index", 70, 1);
    pending = '1; for (int k = 0; k < NL; k++) pr[k] = 0;
    runExpect("R3 all tied", 95, 1);
  endtask

  task automatic t_bank();
    clearAll(); pending[65] = 1;
    runExpect("R4 bank2 bit1", 65, 1);
    clearAll(); pending[63] = 1;
    runExpect("R4 bank1 bit31", 63, 1);
  endtask

  task automatic t_hold();
    clearAll(); pending[50] = 1;
    runExpect("R7 setup", 50, 1);
    pending = '0; pending[2] = 1;
    repeat (3) @(negedge clk);
    check("R7 hold new line", int'(winCode), int'(winValid), 50, 1);
    pending = '0;
    repeat (2) @(negedge clk);
    check("R7 hold empty", int'(winCode), int'(winValid), 50, 1);
  endtask

  task automatic t_random();
    int mc, mv;
    for (int n = 0; n < 30; n++) begin
      pending  = {$urandom, $urandom, $urandom};
      maskBits = {$urandom, $urandom, $urandom};
      classSel = {$urandom, $urandom, $urandom};
      fastClass = 1'($urandom);
      for (int k = 0; k < NL; k++) pr[k] = 5'($urandom % 4);
      doCapture();
      model(mc, mv);
      check("R1 R2 R3 random", int'(winCode), int'(winValid), mc, mv);
    end
  endtask

  initial begin
    clearAll();
    repeat (3) @(posedge clk);
    t_reset();
    t_empty();
    t_line0();
    t_mask();
    t_class();
    t_priority();
    t_tie();
    t_bank();
    t_hold();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: code=%0d valid=%0d expected completion", winCode, winValid);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule